// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This unit collects interrupt events for a peripheral interface adapter and folds them into one active-high request line. Seven event sources each own one flag bit: two timers, a shift register and four handshake edge inputs. Each source raises its flag with a set strobe and may drop it with a clear strobe. A source that presents a level drives set with the level and clear with its inverse. The host register decoder adds three read-side-effect clear strobes. These fire when software reads the timer-1 counter low byte, the timer-2 counter low byte or the shift register.

Software reaches the unit through an 8-bit port with one select line. Select 0 addresses the flag register and select 1 addresses the enable register. Flags are cleared by writing ones. Enables are changed by a write whose top bit chooses between setting and clearing the addressed bits. Reading the flags reports, in bit 7, whether any enabled flag is pending. The request output is registered.

Top module: `irq_flag_enable_unit`

## Requirements
- R1: `irq` is high in the cycle after a clock edge exactly when the flag and enable registers held at least one common set bit before that edge, so it lags every flag or enable change by one clock.
- R2: A host write with `host_sel`=0 clears each flag bit whose matching `host_wdata` bit in [6:0] is 1, and it leaves the other flag bits unchanged.
- R3: A host write with `host_sel`=1 and `host_wdata[7]`=1 sets each enable bit whose data bit in [6:0] is 1, and it leaves the rest unchanged.
- R4: A host write with `host_sel`=1 and `host_wdata[7]`=0 clears each enable bit whose data bit in [6:0] is 1, and it leaves the rest unchanged.
- R5: With `host_sel`=1, `host_rdata` shows the enable bits in [6:0], and bit 7 always reads 1.
- R6: With `host_sel`=0, `host_rdata` shows the flag bits in [6:0], and bit 7 reads 1 only when some flag is both set and enabled.
- R7: `src_set[i]` sets flag i at the next edge, and `src_clr[i]` clears it. Flag positions are: timer 1 at bit 6, timer 2 at bit 5, shift register at bit 2, and handshake inputs at bits 4, 3, 1 and 0.
- R8: `rd_clr[0]` (timer-1 counter low byte read) clears flag 6. `rd_clr[1]` (timer-2 counter low byte read) clears flag 5. `rd_clr[2]` (shift register read) clears flag 2. No other flag is affected.
- R9: When a set strobe and any clear for the same flag arrive in the same cycle, the flag ends up set. The clear may come from `src_clr`, `rd_clr` or a host flag write.
- R10: While `rst` is high at a clock edge, both registers and `irq` become zero.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Register select: 0 flags, 1 enables |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected register |
| src_set | input | 7 | Per-source flag set strobes |
| src_clr | input | 7 | Per-source flag clear strobes |
| rd_clr | input | 3 | Read-side-effect clears: timer 1, timer 2, shift register |
| irq | output | 1 | Registered interrupt request |

## Verification
A source set strobe and a clear aimed at the same flag can land in the same cycle. The clear may come from a host flag write, a read-side-effect strobe or the source's own clear. Directed steps drive each kind of collision on a single edge, and random stimulus produces further overlaps with independent masks. After each edge the flag readback and the delayed request are compared with a bench model in which set overrides every clear.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int unsigned IFU_SRC_W  = 7;
    localparam int unsigned IFU_DATA_W = IFU_SRC_W + 1;

    localparam int unsigned IFU_T1_BIT = 6;
    localparam int unsigned IFU_T2_BIT = 5;
    localparam int unsigned IFU_SR_BIT = 2;

    localparam int unsigned IFU_RDCLR_W = 3;

    typedef enum logic {
        SEL_FLAGS  = 1'b0,
        SEL_ENABLE = 1'b1
    } ifu_sel_e;

    typedef enum logic {
        EN_OP_CLEAR = 1'b0,
        EN_OP_SET   = 1'b1
    } ifu_en_op_e;

    typedef struct packed {
        logic     flag_wr;
        logic     en_wr;
        ifu_sel_e sel;
    } ifu_host_dec_t;

    function automatic ifu_host_dec_t decode_host(input logic wr, input ifu_sel_e sel);
        ifu_host_dec_t d;
        d.sel     = sel;
        d.flag_wr = wr && (sel == SEL_FLAGS);
        d.en_wr   = wr && (sel == SEL_ENABLE);
        return d;
    endfunction

endpackage

// File: rtl/ifu_flag_bank.sv
module ifu_flag_bank #(
    parameter int unsigned SRC_W = ifu_pkg::IFU_SRC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] set_i,
    input  logic [SRC_W-1:0] clr_i,
    output logic [SRC_W-1:0] flags_o
);

    // One cell per source; set dominates clear.
    for (genvar i = 0; i < SRC_W; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                flags_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                flags_o[i] <= 1'b0;
            end
        end
    end

    // R9 / R7: every strobed set is visible after the edge
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R7: an unopposed clear drops the flag
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

    // R2: bits with neither strobe hold their value
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((flags_o ^ $past(flags_o)) & ~$past(set_i | clr_i)) == '0));

endmodule

// File: rtl/ifu_enable_reg.sv
module ifu_enable_reg #(
    parameter int unsigned SRC_W = ifu_pkg::IFU_SRC_W,
    localparam int unsigned DATA_W = SRC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [SRC_W-1:0]  en_o
);
    import ifu_pkg::*;

    ifu_en_op_e       op;
    logic [SRC_W-1:0] mask;
    logic [SRC_W-1:0] en_next;

    assign op   = ifu_en_op_e'(data_i[DATA_W-1]);
    assign mask = data_i[SRC_W-1:0];

    always_comb begin
        en_next = en_o;
        if (wr_i) begin
            unique case (op)
                EN_OP_SET:   en_next = en_o | mask;
                EN_OP_CLEAR: en_next = en_o & ~mask;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_o <= '0;
        else     en_o <= en_next;
    end

    // R3: a set-type write makes the addressed bits one
    assert_en_set_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_i && data_i[DATA_W-1]) |=> ((en_o & $past(mask)) == $past(mask)));

    // R4: a clear-type write makes the addressed bits zero
    assert_en_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !data_i[DATA_W-1]) |=> ((en_o & $past(mask)) == '0));

    // R3 / R4: with no write the enables stay put
    assert_en_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(en_o));

endmodule

// File: rtl/ifu_irq_out.sv
module ifu_irq_out #(
    parameter int unsigned SRC_W = ifu_pkg::IFU_SRC_W,
    localparam int unsigned DATA_W = SRC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  flags_i,
    input  logic [SRC_W-1:0]  en_i,
    input  ifu_pkg::ifu_sel_e sel_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] rdata_o
);
    import ifu_pkg::*;

    logic pending;

    assign pending = |(flags_i & en_i);

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= pending;
    end

    always_comb begin
        unique case (sel_i)
            SEL_FLAGS:  rdata_o = {pending, flags_i};
            SEL_ENABLE: rdata_o = {1'b1, en_i};
        endcase
    end

    // R1: the request follows the masked flags one clock later
    assert_irq_lag_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(flags_i & en_i))));

    // R6: a reported pending status implies a set, enabled flag
    assert_status_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SEL_FLAGS && rdata_o[DATA_W-1]) |-> ((flags_i & en_i) != '0));

endmodule

// File: rtl/irq_flag_enable_unit.sv
module irq_flag_enable_unit #(
    parameter int unsigned SRC_W   = ifu_pkg::IFU_SRC_W,
    parameter int unsigned RDCLR_W = ifu_pkg::IFU_RDCLR_W,
    parameter int unsigned T1_BIT  = ifu_pkg::IFU_T1_BIT,
    parameter int unsigned T2_BIT  = ifu_pkg::IFU_T2_BIT,
    parameter int unsigned SR_BIT  = ifu_pkg::IFU_SR_BIT,
    localparam int unsigned DATA_W = SRC_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_sel,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic [SRC_W-1:0]   src_set,
    input  logic [SRC_W-1:0]   src_clr,
    input  logic [RDCLR_W-1:0] rd_clr,
    output logic               irq
);
    import ifu_pkg::*;

    ifu_host_dec_t    dec;
    logic [SRC_W-1:0] rd_mask;
    logic [SRC_W-1:0] wr_mask;
    logic [SRC_W-1:0] clr_all;
    logic [SRC_W-1:0] flags;
    logic [SRC_W-1:0] enables;

    assign dec = decode_host(host_wr, ifu_sel_e'(host_sel));

    // Map read-side-effect strobes onto their flag positions (R8)
    always_comb begin
        rd_mask         = '0;
        rd_mask[T1_BIT] = rd_clr[0];
        rd_mask[T2_BIT] = rd_clr[1];
        rd_mask[SR_BIT] = rd_clr[2];
    end

    assign wr_mask = dec.flag_wr ? host_wdata[SRC_W-1:0] : '0;
    assign clr_all = src_clr | rd_mask | wr_mask;

    ifu_flag_bank #(.SRC_W(SRC_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (src_set),
        .clr_i   (clr_all),
        .flags_o (flags)
    );

    ifu_enable_reg #(.SRC_W(SRC_W)) u_enables (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (dec.en_wr),
        .data_i (host_wdata),
        .en_o   (enables)
    );

    ifu_irq_out #(.SRC_W(SRC_W)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .flags_i (flags),
        .en_i    (enables),
        .sel_i   (dec.sel),
        .irq_o   (irq),
        .rdata_o (host_rdata)
    );

    // R8: an unopposed timer-1 read clear leaves flag 6 low
    assert_rdclr_t1_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_clr[0] && !src_set[T1_BIT]) |=> !flags[T1_BIT]);

    // R2: host flag write clears the addressed, unopposed bits
    assert_flag_wr_R2: assert property (@(posedge clk) disable iff (rst)
        dec.flag_wr |=> ((flags & $past(host_wdata[SRC_W-1:0] & ~src_set)) == '0));

    // R5: the enable readback carries a constant top bit
    assert_en_read_R5: assert property (@(posedge clk) disable iff (rst)
        host_sel |-> host_rdata[DATA_W-1]);

endmodule

// File: tb/test_irq_flag_enable_unit.sv
module test_irq_flag_enable_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr;
    logic       host_sel;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic [6:0] src_set;
    logic [6:0] src_clr;
    logic [2:0] rd_clr;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [6:0] m_flags = '0;
    logic [6:0] m_en    = '0;
    logic       m_irq   = 1'b0;

    always #4 clk = ~clk;

    irq_flag_enable_unit i_irq_flag_enable_unit (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .src_set(src_set), .src_clr(src_clr), .rd_clr(rd_clr), .irq(irq)
    );

    function automatic logic [6:0] rd_expand(input logic [2:0] r);
        logic [6:0] m = '0;
        m[6] = r[0];
        m[5] = r[1];
        m[2] = r[2];
        return m;
    endfunction

    function automatic logic [6:0] next_flags(input logic [6:0] f, input logic wr, input logic sel,
                                              input logic [7:0] wd, input logic [6:0] s,
                                              input logic [6:0] c, input logic [2:0] r);
        logic [6:0] n = f;
        if (wr && !sel) n = n & ~wd[6:0];
        n = n & ~c & ~rd_expand(r);
        return n | s;
    endfunction

    function automatic logic [6:0] next_en(input logic [6:0] e, input logic wr, input logic sel,
                                           input logic [7:0] wd);
        if (!(wr && sel)) return e;
        return wd[7] ? (e | wd[6:0]) : (e & ~wd[6:0]);
    endfunction

    function automatic logic [7:0] exp_read(input logic sel, input logic [6:0] f, input logic [6:0] e);
        return sel ? {1'b1, e} : {|(f & e), f};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic sel, input logic [7:0] wd,
                        input logic [6:0] s, input logic [6:0] c, input logic [2:0] r,
                        input string tag);
        logic [6:0] nf;
        logic [6:0] ne;
        @(negedge clk);
        host_wr = wr; host_sel = sel; host_wdata = wd;
        src_set = s; src_clr = c; rd_clr = r;
        #1;
        check({tag, " readback"}, host_rdata, exp_read(sel, m_flags, m_en));
        nf = next_flags(m_flags, wr, sel, wd, s, c, r);
        ne = next_en(m_en, wr, sel, wd);
        @(posedge clk);
        #1;
        m_irq   = |(m_flags & m_en);
        m_flags = nf;
        m_en    = ne;
        check({tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
    endtask

    task automatic peek(input logic sel, input string tag);
        step(1'b0, sel, 8'h00, '0, '0, '0, tag);
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; host_wr = 0; host_sel = 0; host_wdata = 0;
        src_set = 0; src_clr = 0; rd_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state, R5 enable read top bit
        peek(1'b0, "R10 flags after reset");
        peek(1'b1, "R10 R5 enables after reset");

        // R3 set enables, R4 clear some
        step(1'b1, 1'b1, 8'hFF, '0, '0, '0, "R3 set all enables");
        peek(1'b1, "R5 R3 enable read");
        step(1'b1, 1'b1, 8'h05, '0, '0, '0, "R4 clear enables 0 and 2");
        peek(1'b1, "R4 enable read");

        // R7 set strobes, R1 one-cycle lag, R6 status bit
        step(1'b0, 1'b0, 8'h00, 7'h04, '0, '0, "R7 set masked flag 2");
        peek(1'b0, "R6 masked flag no status");
        step(1'b0, 1'b0, 8'h00, 7'h40, '0, '0, "R7 R1 set flag 6");
        peek(1'b0, "R1 R6 status and irq");
        step(1'b0, 1'b0, 8'h00, '0, 7'h40, '0, "R7 clear flag 6");
        peek(1'b0, "R1 irq drops");

        // R2 flag write clears ones only
        step(1'b0, 1'b0, 8'h00, 7'h7F, '0, '0, "R7 set all flags");
        step(1'b1, 1'b0, 8'h8A, '0, '0, '0, "R2 clear flags 3 and 1");
        peek(1'b0, "R2 flag read");

        // R8 read-side clears, one at a time
        step(1'b0, 1'b0, 8'h00, '0, '0, 3'b001, "R8 timer1 read clear");
        peek(1'b0, "R8 after timer1");
        step(1'b0, 1'b0, 8'h00, '0, '0, 3'b010, "R8 timer2 read clear");
        peek(1'b0, "R8 after timer2");
        step(1'b0, 1'b0, 8'h00, '0, '0, 3'b100, "R8 shift read clear");
        peek(1'b0, "R8 after shift");

        // R9 collisions
        step(1'b1, 1'b0, 8'h7F, 7'h10, '0, '0, "R9 set vs host write");
        peek(1'b0, "R9 flag 4 kept");
        step(1'b0, 1'b0, 8'h00, 7'h40, '0, 3'b001, "R9 set vs timer1 read");
        peek(1'b0, "R9 flag 6 kept");
        step(1'b0, 1'b0, 8'h00, 7'h21, 7'h21, 3'b010, "R9 set vs source clear");
        peek(1'b0, "R9 flags 5 and 0 kept");

        // R10 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        m_flags = '0; m_en = '0; m_irq = 1'b0;
        @(negedge clk); rst = 1'b0;
        peek(1'b0, "R10 flags after second reset");
        peek(1'b1, "R10 enables after second reset");

        // Random mix: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < 4000; k++) begin
            logic       w   = ($urandom_range(0, 3) == 0);
            logic       sl  = $urandom_range(0, 1);
            logic [7:0] wd  = 8'($urandom);
            logic [6:0] s   = 7'($urandom & $urandom & $urandom);
            logic [6:0] c   = 7'($urandom & $urandom);
            logic [2:0] r   = 3'($urandom & $urandom);
            step(w, sl, wd, s, c, r, "R1 R6 R9 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule